// File: doc/BRIEF.md
# Register-Access SPI Slave

This block lets an external host read and write a bank of registers of mixed width over a four-wire serial link. The link runs in SPI mode 3. Each frame starts with a command byte and a 16-bit register address. Data bytes follow, and their number is set by the width of the addressed register. The serial pins are brought into the system clock domain through synchronizers. The block then drives a plain parallel bus toward the register bank: an address, write data and a single-cycle write strobe. The bank answers with read data and a two-bit width code for the address being presented.

Each register is given one width code per address. This lets the bank place the same value at two addresses, for example one 24-bit view and one 32-bit view. A write-lock input keeps write frames running on the wire but stops them from reaching the bank. Three capture outputs hold the command, address and data of the last frame that completed with effect. A host can read these back to confirm that a transfer arrived intact.

Top module: `regspi_slave`

## Requirements
- R1: A frame is a command byte followed by a 16-bit address, both sent MSB first. Command bit 7 set (0x80) marks a read, and bit 7 clear (0x00) marks a write. Data bits start after the 24th SCLK rising edge.
- R2: MOSI is sampled on SCLK rising edges. MISO changes only on SCLK falling edges or when chip select is released. Data travels MSB first in both directions.
- R3: The number of data bytes is reg_width+1, with 0 for 8 bits, 1 for 16, 2 for 24 and 3 for 32. A read of a narrow view returns only the low 8*(reg_width+1) bits of reg_rdata.
- R4: After the last data bit of a write frame, reg_we pulses for exactly one clk cycle. During that pulse reg_addr carries the frame address and reg_wdata carries the received data, right-aligned.
- R5: In a read frame, MISO carries the addressed register value, starting with its most significant bit within the width.
- R6: While wr_lock is high, a write frame runs to completion on the wire but produces no reg_we and leaves the capture outputs unchanged. When wr_lock is low again, writes work as before.
- R7: After each read frame, and each unlocked write frame, that completes, last_cmd, last_addr and last_data hold that frame's command (0x80 or 0x00), address and data.
- R8: If cs_n rises before the last data bit, the frame is dropped: there is no reg_we and no capture update.
- R9: After reset, reg_we is 0, MISO is 0 and all capture outputs are 0.
- R10: SCLK edges that arrive after a frame has completed, while cs_n is still low, are ignored. They cause no second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| wr_lock | input | 1 | When high, write frames do not reach the bank |
| reg_addr | output | 16 | Register address toward the bank |
| reg_wdata | output | 32 | Write data, right-aligned |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 32 | Read data from the bank for reg_addr |
| reg_width | input | 2 | Width code of reg_addr |
| last_cmd | output | 8 | Command of the last completed frame |
| last_addr | output | 16 | Address of the last completed frame |
| last_data | output | 32 | Data of the last completed frame |

## Verification
Some rules are checked by assertions on every cycle:
- the write strobe lasts a single cycle;
- it is never raised by a read frame or while the lock is high;
- MISO moves only after a falling SCLK edge or a chip-select release;
- the capture registers hold their value unless a capture is signalled.

Other behaviours only show up in the bench's frame scenarios. These are the per-width byte counts, the MSB-first bit order, the 24-bit versus 32-bit views of one value, dropped frames, locked writes and surplus clocks. In those scenarios, the scoreboard compares every write that reaches the bank and every captured record against the expected values.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
    localparam int CMD_W    = 8;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int WSEL_W   = 2;
    localparam int HDR_BITS = CMD_W + ADDR_W;
    localparam int CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CMD_W-1:0] CMD_RD = 8'h80;
    localparam logic [CMD_W-1:0] CMD_WR = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_LOAD,
        PH_DATA,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/regspi_sync.sv
module regspi_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3,
    parameter logic [W-1:0] RSTV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= RSTV;
                else        chain_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= RSTV;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/regspi_frame.sv
module regspi_frame
    import regspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [WSEL_W-1:0] reg_width,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              miso,
    output logic              cap_en,
    output logic              cap_rd,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  dlen;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rdv;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              sck;
        logic              miso;
        logic              we;
        logic              cap;
    } fr_t;

    localparam fr_t FR_RST = '{ph: PH_IDLE, sck: 1'b1, default: '0};

    fr_t q, n;
    logic              rise, fall;
    logic [DATA_W-1:0] sh_nx;
    logic [CNT_W-1:0]  dlen_nx;

    assign rise = sclk_s & ~q.sck;
    assign fall = ~sclk_s & q.sck;

    always_comb begin
        n       = q;
        n.we    = 1'b0;
        n.cap   = 1'b0;
        n.sck   = sclk_s;
        sh_nx   = {q.sh[DATA_W-2:0], mosi_s};
        dlen_nx = CNT_W'(({{(CNT_W-WSEL_W){1'b0}}, reg_width} + CNT_W'(1)) << 3);
        if (cs_n_s) begin
            n.ph   = PH_IDLE;
            n.cnt  = '0;
            n.miso = 1'b0;
        end else begin
            unique case (q.ph)
                PH_IDLE: begin
                    n.ph  = PH_HDR;
                    n.cnt = '0;
                    n.sh  = '0;
                    n.tx  = '0;
                end
                PH_HDR: begin
                    if (fall) n.miso = 1'b0;
                    if (rise) begin
                        n.sh  = sh_nx;
                        n.cnt = q.cnt + CNT_W'(1);
                        if (q.cnt == CNT_W'(HDR_BITS - 1)) begin
                            n.rd   = sh_nx[HDR_BITS-1];
                            n.addr = sh_nx[ADDR_W-1:0];
                            n.cnt  = '0;
                            n.ph   = PH_LOAD;
                        end
                    end
                end
                PH_LOAD: begin
                    n.dlen = dlen_nx;
                    n.tx   = reg_rdata << (CNT_W'(DATA_W) - dlen_nx);
                    n.rdv  = reg_rdata & ({DATA_W{1'b1}} >> (CNT_W'(DATA_W) - dlen_nx));
                    n.sh   = '0;
                    n.ph   = PH_DATA;
                end
                PH_DATA: begin
                    if (fall) begin
                        n.miso = q.tx[DATA_W-1];
                        n.tx   = {q.tx[DATA_W-2:0], 1'b0};
                    end
                    if (rise) begin
                        n.sh  = sh_nx;
                        n.cnt = q.cnt + CNT_W'(1);
                        if (q.cnt == q.dlen - CNT_W'(1)) begin
                            n.ph = PH_DONE;
                            if (q.rd) begin
                                n.cap = 1'b1;
                            end else if (!wr_lock) begin
                                n.we  = 1'b1;
                                n.cap = 1'b1;
                            end
                        end
                    end
                end
                PH_DONE: ;
                default: n.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FR_RST;
        else        q <= n;
    end

    assign reg_addr  = q.addr;
    assign reg_wdata = q.sh;
    assign reg_we    = q.we;
    assign miso      = q.miso;
    assign cap_en    = q.cap;
    assign cap_rd    = q.rd;
    assign cap_addr  = q.addr;
    assign cap_data  = q.rd ? q.rdv : q.sh;

    assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_we_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !$past(wr_lock));
    assert_we_not_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !q.rd);
    assert_miso_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(fall || cs_n_s));
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DATA_W));
endmodule

// File: rtl/regspi_lastop.sv
module regspi_lastop
    import regspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_rd,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    output logic [CMD_W-1:0]  last_cmd,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rec_t;

    rec_t rec_q, rec_d;

    always_comb begin
        rec_d = rec_q;
        if (cap_en) begin
            rec_d.cmd  = cap_rd ? CMD_RD : CMD_WR;
            rec_d.addr = cap_addr;
            rec_d.data = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign last_cmd  = rec_q.cmd;
    assign last_addr = rec_q.addr;
    assign last_data = rec_q.data;

    assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(rec_q));
    assert_cap_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cmd == CMD_RD) || (last_cmd == CMD_WR));
endmodule

// File: rtl/regspi_slave.sv
module regspi_slave
    import regspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    input  logic              wr_lock,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [WSEL_W-1:0] reg_width,
    output logic [CMD_W-1:0]  last_cmd,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    logic [2:0]        pins_s;
    logic              cap_en, cap_rd;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    regspi_sync #(.STAGES(SYNC_STAGES), .W(3), .RSTV(3'b011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mosi, sclk, cs_n}),
        .dout (pins_s)
    );

    regspi_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[0]),
        .sclk_s   (pins_s[1]),
        .mosi_s   (pins_s[2]),
        .wr_lock  (wr_lock),
        .reg_rdata(reg_rdata),
        .reg_width(reg_width),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .miso     (miso),
        .cap_en   (cap_en),
        .cap_rd   (cap_rd),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    regspi_lastop u_last (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_rd   (cap_rd),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .last_cmd (last_cmd),
        .last_addr(last_addr),
        .last_data(last_data)
    );
endmodule

// File: tb/tb_regspi_slave.sv
`timescale 1ns/1ps
module tb_regspi_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, mosi, wr_lock;
    logic        miso, reg_we;
    logic [15:0] reg_addr, last_addr;
    logic [31:0] reg_wdata, reg_rdata, last_data;
    logic [1:0]  reg_width;
    logic [7:0]  last_cmd;
    logic [31:0] mem [16];

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_addr[$];
    logic [31:0] exp_data[$];
    string       exp_tag[$];

    always #2 clk = ~clk;

    regspi_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .wr_lock(wr_lock), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .reg_width(reg_width), .last_cmd(last_cmd), .last_addr(last_addr),
        .last_data(last_data)
    );

    // Bank model: width code from address bits 9:8, storage by address bits 3:0
    assign reg_width = reg_addr[9:8];
    assign reg_rdata = mem[reg_addr[3:0]];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if (reg_we) begin
            mem[reg_addr[3:0]] <= reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every bank write must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_addr.size() == 0) begin
                chk(1'b0, "R6 R8 R10 unexpected write", {16'h0, reg_addr}, 32'h0);
            end else begin
                automatic logic [15:0] ea = exp_addr.pop_front();
                automatic logic [31:0] ed = exp_data.pop_front();
                automatic string       et = exp_tag.pop_front();
                chk(reg_addr == ea, et, {16'h0, reg_addr}, {16'h0, ea});
                chk(reg_wdata == ed, et, reg_wdata, ed);
            end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_tag.push_back(tag);
    endtask

    // Mode 3 frame: SCLK idles high, MOSI set after falling edge, MISO sampled before rising
    task automatic spi_frame(input logic [7:0] cmd, input logic [15:0] addr,
                             input logic [31:0] wdata, input int nbytes,
                             input int send_bits, output logic [31:0] rdata);
        logic [55:0] tx;
        tx = {cmd, addr, wdata << (32 - 8 * nbytes)};
        rdata = '0;
        cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < send_bits; i++) begin
            sclk = 1'b0;
            mosi = tx[55 - i];
            wait_clks(HALF);
            if (i >= 24) rdata = {rdata[30:0], miso};
            sclk = 1'b1;
            wait_clks(HALF);
        end
        wait_clks(HALF);
        cs_n = 1'b1;
        wait_clks(20);
    endtask

    task automatic cap_chk(input string tag, input logic [7:0] c, input logic [15:0] a, input logic [31:0] d);
        chk(last_cmd == c, tag, {24'h0, last_cmd}, {24'h0, c});
        chk(last_addr == a, tag, {16'h0, last_addr}, {16'h0, a});
        chk(last_data == d, tag, last_data, d);
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait_clks(150000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        report();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; mosi = 1'b0; wr_lock = 1'b0;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);

        // R9 reset state
        chk(reg_we == 1'b0, "R9 reg_we", {31'h0, reg_we}, 32'h0);
        chk(miso == 1'b0, "R9 miso", {31'h0, miso}, 32'h0);
        cap_chk("R9 capture", 8'h00, 16'h0000, 32'h0);

        // R1 R3 R4 writes of each width, MSB first (R2)
        expect_wr(16'h0012, 32'h000000A5, "R4 R3 8-bit write");
        spi_frame(8'h00, 16'h0012, 32'hA5, 1, 32, rd);
        cap_chk("R7 write capture", 8'h00, 16'h0012, 32'hA5);

        expect_wr(16'h0103, 32'h0000BEEF, "R4 R3 16-bit write");
        spi_frame(8'h00, 16'h0103, 32'hBEEF, 2, 40, rd);

        expect_wr(16'h0307, 32'hDEADBEEF, "R4 R2 32-bit write");
        spi_frame(8'h00, 16'h0307, 32'hDEADBEEF, 4, 56, rd);
        cap_chk("R7 write capture 32", 8'h00, 16'h0307, 32'hDEADBEEF);

        // R5 reads
        spi_frame(8'h80, 16'h0307, 32'h0, 4, 56, rd);
        chk(rd == 32'hDEADBEEF, "R5 R2 32-bit read", rd, 32'hDEADBEEF);
        cap_chk("R7 read capture", 8'h80, 16'h0307, 32'hDEADBEEF);

        spi_frame(8'h80, 16'h0207, 32'h0, 3, 48, rd);
        chk(rd == 32'h00ADBEEF, "R3 24-bit alias read", rd, 32'h00ADBEEF);
        cap_chk("R7 alias capture", 8'h80, 16'h0207, 32'h00ADBEEF);

        spi_frame(8'h80, 16'h0012, 32'h0, 1, 32, rd);
        chk(rd == 32'hA5, "R5 8-bit read", rd, 32'hA5);

        spi_frame(8'h80, 16'h0103, 32'h0, 2, 40, rd);
        chk(rd == 32'hBEEF, "R5 16-bit read", rd, 32'hBEEF);

        // R6 write lock
        wr_lock = 1'b1;
        spi_frame(8'h00, 16'h0103, 32'h1234, 2, 40, rd);
        cap_chk("R6 locked capture kept", 8'h80, 16'h0103, 32'hBEEF);
        spi_frame(8'h80, 16'h0103, 32'h0, 2, 40, rd);
        chk(rd == 32'hBEEF, "R6 locked write ignored", rd, 32'hBEEF);
        wr_lock = 1'b0;
        expect_wr(16'h0103, 32'h00001234, "R6 unlocked write");
        spi_frame(8'h00, 16'h0103, 32'h1234, 2, 40, rd);
        spi_frame(8'h80, 16'h0103, 32'h0, 2, 40, rd);
        chk(rd == 32'h1234, "R6 unlocked readback", rd, 32'h1234);

        // R8 aborted frame
        spi_frame(8'h00, 16'h0305, 32'hCAFEF00D, 4, 54, rd);
        cap_chk("R8 abort capture kept", 8'h80, 16'h0103, 32'h1234);
        spi_frame(8'h80, 16'h0305, 32'h0, 4, 56, rd);
        chk(rd == 32'h0, "R8 abort no write", rd, 32'h0);

        // R10 surplus clocks after completion
        expect_wr(16'h0009, 32'h0000005A, "R10 single write");
        spi_frame(8'h00, 16'h0009, 32'h5A77, 2, 40, rd);
        cap_chk("R10 capture", 8'h00, 16'h0009, 32'h5A);
        spi_frame(8'h80, 16'h0009, 32'h0, 1, 32, rd);
        chk(rd == 32'h5A, "R10 readback", rd, 32'h5A);

        chk(exp_addr.size() == 0, "R4 all writes seen", exp_addr.size(), 32'h0);
        report();
    end
endmodule